// File: doc/BRIEF.md
# Four-Channel DAC Update Controller

This block sits behind a register bus and drives the digital side of four 12-bit DAC channels. Software loads the next code into one shared code register. It then writes the command register with a channel number, a range selection and the start bit. The start write copies the pending code, together with the range taken from that same write, into the chosen channel's output latch in one clock edge.

After each commit the block reports busy on the start bit position for a settling window of a parameterised length. A start written during that window is dropped. When the window closes, a ready flag is raised in an interrupt status register, and software clears it by writing a one. Reset returns every channel to code zero on the unipolar 5 V range.

Top module: `dacctl_top`

## Requirements
- R1: After reset every channel code and range output is zero (unipolar 5 V, code 0), the ready flag and irq output are low, and the command register reads zero.
- R2: The command register sits at byte offset 0x04. Bits 9:8 select the channel, bit 4 selects bipolar and bit 5 selects the 10 V span. Every written bit except bit 0 is stored and read back, and bit 0 reads as busy.
- R3: The code register at byte offset 0x06 stores the low 12 bits of a write and reads them back zero-extended. Writing it changes no channel output.
- R4: A command write with bit 0 set, issued while idle, loads the pending code into the channel named by bits 9:8 of that write, on the clock edge that accepts the write. Channel n's code appears on dac_code[12n+11:12n]. Its range appears on dac_span[2n+1:2n], where bit 1 is the 10 V span and bit 0 is bipolar, and it is taken from the same write. Other channels keep their values.
- R5: After an accepted commit, command register bit 0 reads 1 for exactly SETTLE_CYC cycles and then 0.
- R6: A start write issued while busy changes no output and does not extend the busy window.
- R7: When the busy window ends, bit 1 of the interrupt status register at byte offset 0x0E becomes 1, and ready_irq follows it.
- R8: Writing 1 to bit 1 of the interrupt status register clears the flag. Writing 0 leaves it set.
- R9: If the end of a busy window and a clearing write fall on the same edge, the flag ends up set.
- R10: Reads from any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| ready_irq | output | 1 | Ready flag from the interrupt status register |
| dac_code | output | 48 | Four 12-bit channel codes, channel 0 in the low bits |
| dac_span | output | 8 | Four 2-bit range fields, channel 0 in the low bits |

## Verification
Two things can land on the same clock edge: the ready event that ends a settling window, and a software write that clears the ready flag. The bench counts cycles from a commit and places the clearing write exactly on the edge where busy drops. It then expects the flag to read 1. A second clearing write one edge later must leave it at 0. A start written on the cycle right after a commit collides with the running window, and it is judged by unchanged channel outputs and by a busy count shortened by one.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;

    localparam int ADDR_W = 5;
    localparam int BUS_W  = 16;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_CMD  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CODE = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_IRQ  = 5'h0E;

    // bit positions in the command and interrupt status words
    localparam int BIT_GO   = 0;
    localparam int BIT_RDY  = 1;
    localparam int BIT_BIP  = 4;
    localparam int BIT_SPAN = 5;
    localparam int BIT_CH   = 8;

    typedef struct packed {
        logic span10;
        logic bipolar;
    } span_t;

    localparam span_t SPAN_RESET = '{span10: 1'b0, bipolar: 1'b0};

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_CODE,
        SEL_IRQ
    } regsel_t;

    function automatic span_t decode_span(input logic [BUS_W-1:0] w);
        span_t s;
        s.span10  = w[BIT_SPAN];
        s.bipolar = w[BIT_BIP];
        return s;
    endfunction

    function automatic regsel_t decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CMD:  return SEL_CMD;
            OFS_CODE: return SEL_CODE;
            OFS_IRQ:  return SEL_IRQ;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dacctl_settle.sv
module dacctl_settle #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic ready_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CNT_W'(SETTLE_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o  = (cnt_q != '0);
    assign ready_o = (cnt_q == CNT_W'(1));

    // R5: an accepted start makes the channel busy on the next cycle
    p_busy_after_start_r5: assert property (@(posedge clk) disable iff (rst)
        start_i |=> busy_o);

    // R5: the ready event closes the window
    p_ready_ends_busy_r5: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> !busy_o);

    // R6: the register interface never restarts a running window
    p_start_only_idle_r6: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !busy_o);

endmodule

// File: rtl/dacctl_chan.sv
module dacctl_chan
    import dacctl_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [CODE_W-1:0] code_i,
    input  span_t             span_i,
    output logic [CODE_W-1:0] code_o,
    output span_t             span_o
);
    logic [CODE_W-1:0] code_q;
    span_t             span_q;

    // code and range move on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            span_q <= SPAN_RESET;
        end else if (load_i) begin
            code_q <= code_i;
            span_q <= span_i;
        end
    end

    assign code_o = code_q;
    assign span_o = span_q;

endmodule

// File: rtl/dacctl_regif.sv
module dacctl_regif
    import dacctl_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              busy_i,
    input  logic              ready_i,
    output logic              commit_o,
    output logic [CH_W-1:0]   sel_ch_o,
    output span_t             sel_span_o,
    output logic [CODE_W-1:0] pend_code_o,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              flag_o
);
    regsel_t sel;
    logic    wr_cmd, wr_code, wr_irq;

    logic [BUS_W-1:1]  cmd_q;
    logic [CODE_W-1:0] code_q;
    logic              flag_q;

    assign sel     = decode_addr(addr);
    assign wr_cmd  = wr_en && (sel == SEL_CMD);
    assign wr_code = wr_en && (sel == SEL_CODE);
    assign wr_irq  = wr_en && (sel == SEL_IRQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            code_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_cmd) begin
                cmd_q <= wdata[BUS_W-1:1];
            end
            if (wr_code) begin
                code_q <= wdata[CODE_W-1:0];
            end
            // set has priority over the write-one-to-clear
            if (ready_i) begin
                flag_q <= 1'b1;
            end else if (wr_irq && wdata[BIT_RDY]) begin
                flag_q <= 1'b0;
            end
        end
    end

    // channel and range come from the very write that carries start
    assign commit_o    = wr_cmd && wdata[BIT_GO] && !busy_i;
    assign sel_ch_o    = wdata[BIT_CH +: CH_W];
    assign sel_span_o  = decode_span(wdata);
    assign pend_code_o = code_q;
    assign flag_o      = flag_q;

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_CMD:  rdata_o = {cmd_q, busy_i};
            SEL_CODE: rdata_o[CODE_W-1:0] = code_q;
            SEL_IRQ:  rdata_o[BIT_RDY] = flag_q;
            default:  rdata_o = '0;
        endcase
    end

    // R9: a ready event always leaves the flag set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        ready_i |=> flag_q);

    // R8: a one written to the ready bit clears it when no event competes
    p_w1c_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_irq && wdata[BIT_RDY] && !ready_i) |=> !flag_q);

endmodule

// File: rtl/dacctl_top.sv
module dacctl_top
    import dacctl_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int CODE_W     = 12,
    parameter int SETTLE_CYC = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [4:0]            bus_addr,
    input  logic [15:0]           bus_wdata,
    output logic [15:0]           bus_rdata,
    output logic                  ready_irq,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic [NCH*2-1:0]      dac_span
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic              commit;
    logic [CH_W-1:0]   sel_ch;
    span_t             sel_span;
    logic [CODE_W-1:0] pend_code;
    logic              busy, ready;

    dacctl_regif #(
        .CODE_W (CODE_W),
        .CH_W   (CH_W)
    ) u_regif (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .busy_i      (busy),
        .ready_i     (ready),
        .commit_o    (commit),
        .sel_ch_o    (sel_ch),
        .sel_span_o  (sel_span),
        .pend_code_o (pend_code),
        .rdata_o     (bus_rdata),
        .flag_o      (ready_irq)
    );

    dacctl_settle #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_settle (
        .clk     (clk),
        .rst     (rst),
        .start_i (commit),
        .busy_o  (busy),
        .ready_o (ready)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic  load;
        span_t span_q;

        assign load = commit && (sel_ch == CH_W'(i));

        dacctl_chan #(
            .CODE_W (CODE_W)
        ) u_chan (
            .clk    (clk),
            .rst    (rst),
            .load_i (load),
            .code_i (pend_code),
            .span_i (sel_span),
            .code_o (dac_code[i*CODE_W +: CODE_W]),
            .span_o (span_q)
        );

        assign dac_span[2*i +: 2] = span_q;
    end

    // R3: a write to the code register alone leaves every output unchanged
    p_code_write_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CODE) |=> ($stable(dac_code) && $stable(dac_span)));

    // R6: a start written while busy leaves every output unchanged
    p_busy_start_dropped_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CMD && bus_wdata[BIT_GO] && busy)
        |=> ($stable(dac_code) && $stable(dac_span)));

    // R7: the end of a settling window shows up on the irq output
    p_irq_at_window_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ready_irq);

endmodule

// File: tb/dacctl_top_tb_top.sv
module dacctl_top_tb_top;
    localparam int NCH = 4;
    localparam int CW  = 12;
    localparam int SC  = 8;

    localparam logic [4:0] A_CMD  = 5'h04;
    localparam logic [4:0] A_CODE = 5'h06;
    localparam logic [4:0] A_IRQ  = 5'h0E;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [4:0]        bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic              ready_irq;
    logic [NCH*CW-1:0] dac_code;
    logic [NCH*2-1:0]  dac_span;

    int tests = 0;
    int fails = 0;

    typedef struct {
        int          ch;
        logic [11:0] code;
        logic [1:0]  sp;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    dacctl_top #(
        .NCH        (NCH),
        .CODE_W     (CW),
        .SETTLE_CYC (SC)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ready_irq (ready_irq),
        .dac_code  (dac_code),
        .dac_span  (dac_span)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // driver: load the code, start the commit, push the expected update
    task automatic commit(input int ch, input logic [1:0] sp, input logic [11:0] code);
        exp_t e;
        bus_write(A_CODE, {4'h0, code});
        e.ch = ch; e.code = code; e.sp = sp;
        exp_q.push_back(e);
        bus_write(A_CMD, 16'(ch << 8) | 16'({sp, 4'h0}) | 16'h1);
    endtask

    task automatic count_busy(output int n);
        logic [15:0] r;
        n = 0;
        bus_read(A_CMD, r);
        while (r[0] && n < 1000) begin
            n++;
            @(negedge clk);
            bus_read(A_CMD, r);
        end
    endtask

    task automatic clear_flag();
        bus_write(A_IRQ, 16'h0002);
    endtask

    // monitor: every channel update must match the next expected item
    initial begin
        logic [NCH*CW-1:0] pc;
        logic [NCH*2-1:0]  ps;
        pc = '0;
        ps = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                for (int i = 0; i < NCH; i++) begin
                    if (dac_code[i*CW +: CW] !== pc[i*CW +: CW] || dac_span[2*i +: 2] !== ps[2*i +: 2]) begin
                        if (exp_q.size() == 0) begin
                            chk("R6 unexpected channel update", 32'(i), 32'hFFFF);
                        end else begin
                            exp_t e;
                            e = exp_q.pop_front();
                            chk("R4 updated channel", 32'(i), 32'(e.ch));
                            chk("R4 channel code", 32'(dac_code[i*CW +: CW]), 32'(e.code));
                            chk("R4 channel range", 32'(dac_span[2*i +: 2]), 32'(e.sp));
                        end
                    end
                end
            end
            pc = dac_code;
            ps = dac_span;
        end
    end

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] r;
        int n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 codes", 32'(dac_code), 32'h0);
        chk("R1 ranges", 32'(dac_span), 32'h0);
        chk("R1 irq", 32'(ready_irq), 32'h0);
        bus_read(A_CMD, r);
        chk("R1 command reg", 32'(r), 32'h0);

        // R10 unmapped offsets
        bus_read(5'h00, r);
        chk("R10 offset 0x00", 32'(r), 32'h0);
        bus_read(5'h08, r);
        chk("R10 offset 0x08", 32'(r), 32'h0);

        // R2 fields stored without start
        bus_write(A_CMD, 16'h0230);
        bus_read(A_CMD, r);
        chk("R2 command readback", 32'(r), 32'h0230);
        chk("R2 no output change", 32'(dac_code), 32'h0);

        // R3 code register alone
        bus_write(A_CODE, 16'hFABC);
        bus_read(A_CODE, r);
        chk("R3 code readback", 32'(r), 32'h0ABC);
        @(negedge clk);
        chk("R3 outputs untouched", 32'(dac_code), 32'h0);
        chk("R3 ranges untouched", 32'(dac_span), 32'h0);

        // R4 R5 R7 first commit: channel 1, bipolar 5 V
        commit(1, 2'b01, 12'h123);
        chk("R4 channel 1 code", 32'(dac_code[CW +: CW]), 32'h123);
        count_busy(n);
        chk("R5 busy length", 32'(n), 32'(SC));
        chk("R7 irq after window", 32'(ready_irq), 32'h1);
        bus_read(A_IRQ, r);
        chk("R7 status bit 1", 32'(r), 32'h0002);

        // R8 write 0 keeps, write 1 clears
        bus_write(A_IRQ, 16'h0000);
        bus_read(A_IRQ, r);
        chk("R8 write zero keeps flag", 32'(r), 32'h0002);
        clear_flag();
        bus_read(A_IRQ, r);
        chk("R8 write one clears flag", 32'(r), 32'h0);
        chk("R8 irq low", 32'(ready_irq), 32'h0);

        // R4 several channels and ranges
        commit(0, 2'b11, 12'hFFF);
        count_busy(n);
        clear_flag();
        commit(3, 2'b10, 12'h001);
        count_busy(n);
        clear_flag();
        commit(2, 2'b01, 12'h800);
        count_busy(n);
        clear_flag();
        chk("R4 channel 0 code", 32'(dac_code[0 +: CW]), 32'hFFF);
        chk("R4 channel 3 code", 32'(dac_code[3*CW +: CW]), 32'h001);
        chk("R4 span vector", 32'(dac_span), 32'b10_01_01_11);

        // R6 start while busy is dropped
        commit(2, 2'b00, 12'h555);
        bus_write(A_CMD, 16'h0031);
        count_busy(n);
        chk("R6 window not extended", 32'(n), 32'(SC - 1));
        chk("R6 channel 0 code kept", 32'(dac_code[0 +: CW]), 32'hFFF);
        chk("R6 channel 0 range kept", 32'(dac_span[1:0]), 32'h3);
        clear_flag();

        // R9 clear on the same edge as the ready event
        commit(1, 2'b10, 12'h3C3);
        repeat (SC - 1) @(negedge clk);
        clear_flag();
        bus_read(A_IRQ, r);
        chk("R9 set wins over clear", 32'(r), 32'h0002);
        chk("R9 busy over", 32'(bus_rdata[1]), 32'h1);
        bus_read(A_CMD, r);
        chk("R9 idle after window", 32'(r[0]), 32'h0);
        clear_flag();
        chk("R9 later clear works", 32'(ready_irq), 32'h0);

        repeat (2) @(negedge clk);
        chk("R4 all expected updates seen", 32'(exp_q.size()), 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule